// File: doc/BRIEF.md
# Ethernet Receive Delimiter Hunter and Frame Qualifier

This block is the receive front end of a 10/100 Ethernet MAC. It takes either a one-bit serial stream or a four-bit nibble stream from the PHY, selected by a static mode input. It hunts for the end of the preamble, using a rule that depends on the mode. It throws away a frame whose preamble carries two zero bits in a row. Once the delimiter is found, it packs the following bits into bytes, least-significant bit first. Each byte passes through a one-byte holding stage, so the final byte of a frame can be tagged as last when carrier drops.

Address filtering is done by an external unit. A one-cycle request tells that unit that the first eight bytes have been forwarded, and a reject input answers it. A reflected CRC-32 runs over every byte after the delimiter, including the frame check sequence. When carrier falls, a one-cycle completion pulse carries the byte count and three flags: runt, CRC error and address reject. Downstream logic commits a buffer only when the pulse carries no flag, so runts never reach memory.

Top module: `eth_rx_front`

## Requirements
- R1: After reset, `out_valid`, `out_last`, `addr_chk` and `done` are low.
- R2: In serial mode (`mii_mode`=0), the first 21 bits after carrier rises are not examined. From bit index 21 onward (index 0 = first bit), two consecutive 1 bits end the preamble. The following bits are packed into bytes with the first bit at bit 0.
- R3: In serial mode, two consecutive 0 bits at bit index 21 or later, seen while hunting, drop the frame. No byte and no completion pulse appear until carrier has fallen and risen again.
- R4: In nibble mode (`mii_mode`=1), nibbles are paired low nibble first. The preamble ends on the first nibble pair equal to 0xD5 (0x5 then 0xD). Any number of 0x5 nibbles, including none, may precede the pair. Data bytes are likewise assembled low nibble first.
- R5: In nibble mode, two adjacent 0 bits anywhere in the hunted bit stream (bit 0 of each nibble first, including across nibble boundaries) drop the frame with no output and no completion pulse.
- R6: Every byte after the delimiter, including the four check bytes, appears on `out_data` in arrival order. `out_last` is high on the final byte only.
- R7: `addr_chk` pulses for one cycle, together with the eighth forwarded byte. It never pulses for a frame shorter than eight bytes.
- R8: `addr_rej` counts only from the cycle in which `addr_chk` is high up to the end of the frame. A reject asserted earlier has no effect on `done_rej`.
- R9: `done` is a one-cycle pulse in the cycle after the first clock edge at which `crs` is sampled low during a frame. `done_cnt` equals the number of bytes received after the delimiter.
- R10: `done_runt` is high exactly when `done_cnt` is below 64. A 63-byte frame is a runt and a 64-byte frame is not.
- R11: `done_crc_err` is high unless the CRC-32 (polynomial 0x04C11DB7, initial all ones, reflected) over all received bytes leaves the residue 0xC704DD7B. In the reflected register this residue reads as 0xDEBB20E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mii_mode | input | 1 | 1 = nibble stream, 0 = serial stream |
| crs | input | 1 | Carrier sense; its fall ends the frame |
| rx_valid | input | 1 | One bit or nibble is present on rx_data this cycle |
| rx_data | input | 4 | Nibble; bit 0 carries the serial bit |
| addr_rej | input | 1 | External address filter says reject |
| out_valid | output | 1 | Forwarded byte strobe |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Final byte of the frame |
| addr_chk | output | 1 | Eight bytes forwarded; address check may start |
| done | output | 1 | Frame completion pulse |
| done_runt | output | 1 | Frame shorter than 64 bytes |
| done_crc_err | output | 1 | CRC residue wrong |
| done_rej | output | 1 | Address filter rejected the frame |
| done_cnt | output | 16 | Bytes received after the delimiter |

## Verification
The hardest case to reach is a serial preamble in which a 11 pair and a 00 pair both occur inside the first 21 bits, followed by a 11 pair at a legal position. The design must accept the frame without acting on either early pair. The bench builds this preamble bit by bit and checks that the payload comes out intact. A second preamble places a 00 pair at index 30 and must yield silence. For the address window, the bench pulses the reject input during byte 2 of one frame and holds it from byte 20 of another, so the flag separates the two.

// File: rtl/eth_rx_pkg.sv
// Shared types and helpers for the Ethernet receive front end.
// Assumes the CRC is kept in reflected form (bit 0 = first bit on the wire).
package eth_rx_pkg;

    typedef enum logic [1:0] {
        HUNT_PRE  = 2'd0,
        HUNT_DATA = 2'd1,
        HUNT_DROP = 2'd2
    } hunt_e;

    // Residue 0xC704DD7B as seen in a reflected shift register.
    localparam logic [31:0] CRC_RESIDUE_REFL = 32'hDEBB20E3;
    localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;

    // One byte through the reflected CRC-32, bit 0 first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ d[k]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_sfd_hunt.sv
// Delimiter hunter. Serial mode: ignore the first PRE_BITS bits, then a 11
// pair ends the preamble and a 00 pair drops the frame. Nibble mode: a
// 0x5/0xD pair ends the preamble, any adjacent 00 bits drop the frame.
// Assumes crs low returns the hunter to its idle state.
module rx_sfd_hunt
    import eth_rx_pkg::*;
#(
    parameter int          PRE_BITS = 21,
    parameter logic [7:0]  SFD_BYTE = 8'hD5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mii_mode,
    input  logic       crs,
    input  logic       stb,
    input  logic [3:0] din,
    output logic       in_data,
    output logic       data_stb
);
    localparam int CW = $clog2(PRE_BITS + 1);

    hunt_e         state;
    logic [CW-1:0] bit_cnt;
    logic          prev_bit;
    logic [3:0]    last_nib;
    logic          nib_zero;

    // Adjacent-zero detect across the previous bit and the current nibble.
    always_comb begin
        nib_zero = (!prev_bit && !din[0]) || (!din[0] && !din[1]) ||
                   (!din[1] && !din[2])   || (!din[2] && !din[3]);
    end

    // Hunt state machine for both stream modes.
    always_ff @(posedge clk) begin
        if (!rst_n || !crs) begin
            state    <= HUNT_PRE;
            bit_cnt  <= '0;
            prev_bit <= 1'b1;
            last_nib <= 4'h0;
        end else if (stb && state == HUNT_PRE) begin
            if (mii_mode) begin
                if (nib_zero)                     state <= HUNT_DROP;
                else if ({din, last_nib} == SFD_BYTE) state <= HUNT_DATA;
                prev_bit <= din[3];
                last_nib <= din;
            end else begin
                if (bit_cnt >= CW'(PRE_BITS)) begin
                    if (prev_bit && din[0])        state <= HUNT_DATA;
                    else if (!prev_bit && !din[0]) state <= HUNT_DROP;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
                prev_bit <= din[0];
            end
        end
    end

    assign in_data  = (state == HUNT_DATA);
    assign data_stb = stb && in_data;

    // R2 / R4: the data phase starts only after a unit was taken in.
    assert_sfd_after_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_data) |-> $past(stb));

    // R3 / R5: a dropped frame never turns into data.
    assert_drop_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HUNT_DROP) |=> (state != HUNT_DATA));

endmodule

// File: rtl/rx_byte_pack.sv
// Packs data-phase units into bytes, first unit into the lowest bits.
// Serial: 8 bits per byte. Nibble: low nibble then high nibble.
// Assumes the pack position clears whenever the data phase is left.
module rx_byte_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mii_mode,
    input  logic       in_data,
    input  logic       stb,
    input  logic [3:0] din,
    output logic       byte_stb,
    output logic [7:0] byte_val
);
    logic [2:0] pos;
    logic [7:0] sh;
    logic       full;
    logic [7:0] nxt;

    // Next shift value and byte-complete condition.
    always_comb begin
        if (mii_mode) begin
            nxt  = {din, sh[7:4]};
            full = pos[0];
        end else begin
            nxt  = {din[0], sh[7:1]};
            full = (pos == 3'd7);
        end
    end

    // Shift register and position counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_data) begin
            pos <= '0;
            sh  <= '0;
        end else if (stb) begin
            pos <= full ? 3'd0 : pos + 3'd1;
            sh  <= nxt;
        end
    end

    assign byte_stb = stb && full;
    assign byte_val = nxt;

    // R6: bytes only come out during the data phase.
    assert_byte_in_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> in_data);

endmodule

// File: rtl/rx_crc32.sv
// Running reflected CRC-32 over received bytes; flags the good residue.
// Assumes clr is held during every cycle outside a frame.
module rx_crc32
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] d,
    output logic       crc_ok
);
    logic [31:0] crc;

    // CRC register update per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= '1;
        else if (en)       crc <= crc32_step(crc, d);
    end

    assign crc_ok = (crc == CRC_RESIDUE_REFL);

endmodule

// File: rtl/eth_rx_front.sv
// Receive front end: delimiter hunt, byte packing, one-byte hold so the
// final byte can be marked, address-check request, CRC and frame status.
// Assumes mii_mode is static during a frame; rx_valid counts only while crs.
module eth_rx_front #(
    parameter int CNT_W     = 16,
    parameter int RUNT_LEN  = 64,
    parameter int CHK_BYTES = 8,
    parameter int PRE_BITS  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mii_mode,
    input  logic             crs,
    input  logic             rx_valid,
    input  logic [3:0]       rx_data,
    input  logic             addr_rej,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             addr_chk,
    output logic             done,
    output logic             done_runt,
    output logic             done_crc_err,
    output logic             done_rej,
    output logic [CNT_W-1:0] done_cnt
);
    localparam logic [CNT_W-1:0] CHK_AT  = CNT_W'(CHK_BYTES - 1);
    localparam logic [CNT_W-1:0] RUNT_LIM = CNT_W'(RUNT_LEN);

    logic             stb, in_data, data_stb, byte_stb, crc_ok, end_evt;
    logic [7:0]       byte_val, hold;
    logic             have_hold, win, rej_q;
    logic [CNT_W-1:0] rx_cnt, fwd_cnt;

    assign stb     = rx_valid && crs;
    assign end_evt = in_data && !crs;

    rx_sfd_hunt #(.PRE_BITS(PRE_BITS), .SFD_BYTE(8'hD5)) u_hunt (
        .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .crs(crs),
        .stb(stb), .din(rx_data), .in_data(in_data), .data_stb(data_stb));

    rx_byte_pack u_pack (
        .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .in_data(in_data),
        .stb(data_stb), .din(rx_data), .byte_stb(byte_stb), .byte_val(byte_val));

    rx_crc32 u_crc (
        .clk(clk), .rst_n(rst_n), .clr(!in_data), .en(byte_stb),
        .d(byte_val), .crc_ok(crc_ok));

    // Hold stage, forwarding, address window and completion status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_data     <= '0;
            out_last     <= 1'b0;
            addr_chk     <= 1'b0;
            done         <= 1'b0;
            done_runt    <= 1'b0;
            done_crc_err <= 1'b0;
            done_rej     <= 1'b0;
            done_cnt     <= '0;
            hold         <= '0;
            have_hold    <= 1'b0;
            rx_cnt       <= '0;
            fwd_cnt      <= '0;
            win          <= 1'b0;
            rej_q        <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            addr_chk  <= 1'b0;
            done      <= 1'b0;
            if (win && addr_rej) rej_q <= 1'b1;
            if (byte_stb) begin
                hold      <= byte_val;
                have_hold <= 1'b1;
                if (rx_cnt != '1) rx_cnt <= rx_cnt + 1'b1;
                if (have_hold) begin
                    out_valid <= 1'b1;
                    out_data  <= hold;
                    if (fwd_cnt != '1) fwd_cnt <= fwd_cnt + 1'b1;
                    if (fwd_cnt == CHK_AT) begin
                        addr_chk <= 1'b1;
                        win      <= 1'b1;
                    end
                end
            end else if (end_evt) begin
                if (have_hold) begin
                    out_valid <= 1'b1;
                    out_data  <= hold;
                    out_last  <= 1'b1;
                    if (fwd_cnt == CHK_AT) addr_chk <= 1'b1;
                end
                done         <= 1'b1;
                done_runt    <= (rx_cnt < RUNT_LIM);
                done_crc_err <= !crc_ok;
                done_rej     <= rej_q || (win && addr_rej);
                done_cnt     <= rx_cnt;
                have_hold    <= 1'b0;
                rx_cnt       <= '0;
                fwd_cnt      <= '0;
                win          <= 1'b0;
                rej_q        <= 1'b0;
            end
        end
    end

    // R9: completion is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the address request rides on a forwarded byte.
    assert_chk_with_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_chk |-> out_valid);

    // R8: a reject can only stand if the window was open.
    assert_rej_needs_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_rej) |-> $past(win));

endmodule

// File: tb/eth_rx_front_tb.sv
module eth_rx_front_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mii_mode = 1'b0, crs = 1'b0, rx_valid = 1'b0, addr_rej = 1'b0;
    logic [3:0] rx_data = 4'h0;
    logic out_valid, out_last, addr_chk, done, done_runt, done_crc_err, done_rej;
    logic [7:0] out_data;
    logic [15:0] done_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_rx_front u_dut (
        .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .crs(crs),
        .rx_valid(rx_valid), .rx_data(rx_data), .addr_rej(addr_rej),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .addr_chk(addr_chk), .done(done), .done_runt(done_runt),
        .done_crc_err(done_crc_err), .done_rej(done_rej), .done_cnt(done_cnt));

    int n_tests = 0, n_fail = 0;
    logic [7:0] fb [0:127];
    int flen;

    // monitor state
    logic [7:0] cap [0:127];
    int ncap, last_at, chk_cnt, chk_at, done_seen;
    logic m_runt, m_crc, m_rej;
    int m_cnt;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (out_valid) begin
            if (ncap < 128) cap[ncap] = out_data;
            if (out_last) last_at = ncap;
            if (addr_chk) begin chk_cnt++; chk_at = ncap; end
            ncap++;
        end
        if (done) begin
            done_seen++;
            m_runt = done_runt; m_crc = done_crc_err; m_rej = done_rej;
            m_cnt = int'(done_cnt);
        end
    end

    task automatic clear_mon();
        ncap = 0; last_at = -1; chk_cnt = 0; chk_at = -1; done_seen = 0;
        m_runt = 0; m_crc = 0; m_rej = 0; m_cnt = -1;
    endtask

    // Build payload + FCS (reflected CRC-32, FCS sent low byte first).
    task automatic build_frame(input int npay, input int seed, input bit bad);
        logic [31:0] c;
        c = '1;
        for (int i = 0; i < npay; i++) fb[i] = 8'(seed + i * 29);
        for (int i = 0; i < npay; i++)
            for (int k = 0; k < 8; k++)
                c = (c[0] ^ fb[i][k]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        c = ~c;
        for (int i = 0; i < 4; i++) fb[npay + i] = c[8*i +: 8];
        flen = npay + 4;
        if (bad) fb[3] = fb[3] ^ 8'h10;
    endtask

    task automatic unit(input logic [3:0] d);
        @(negedge clk);
        crs = 1'b1; rx_valid = 1'b1; rx_data = d;
    endtask

    task automatic finish_frame();
        @(negedge clk);
        crs = 1'b0; rx_valid = 1'b0; addr_rej = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // variant 0 standard, 1 early 11/00 inside first 21 bits, 2 00 at index 30
    task automatic send_serial(input int variant);
        logic b;
        mii_mode = 1'b0;
        for (int i = 0; i < 64; i++) begin
            b = (i % 2 == 0);
            if (variant == 1 && i < 2) b = 1'b1;
            if (variant == 1 && (i == 2 || i == 3)) b = 1'b0;
            if (variant == 2 && i == 30) b = 1'b0;
            if (i == 63) b = 1'b1;
            unit({3'b000, b});
        end
        for (int j = 0; j < flen; j++)
            for (int k = 0; k < 8; k++) unit({3'b000, fb[j][k]});
        finish_frame();
    endtask

    // npre 0x5 nibbles then 0xD; drop inserts a 0x4 nibble; rej_mode 1/2
    task automatic send_mii(input int npre, input bit drop, input int rej_mode);
        mii_mode = 1'b1;
        for (int i = 0; i < npre; i++) unit(4'h5);
        if (drop) unit(4'h4);
        unit(4'hD);
        for (int j = 0; j < flen; j++) begin
            addr_rej = (rej_mode == 1 && j == 2) || (rej_mode == 2 && j >= 20);
            unit(fb[j][3:0]);
            unit(fb[j][7:4]);
        end
        finish_frame();
    endtask

    task automatic check_frame(input string tag, input bit runt, input bit crcerr, input bit rej);
        int mism;
        mism = 0;
        for (int i = 0; i < flen && i < ncap; i++) if (cap[i] != fb[i]) mism++;
        chk(ncap == flen, {tag, " R6 byte count"}, ncap, flen);
        chk(mism == 0, {tag, " R6 byte values"}, mism, 0);
        chk(last_at == flen - 1, {tag, " R6 last position"}, last_at, flen - 1);
        chk(done_seen == 1, {tag, " R9 done pulses"}, done_seen, 1);
        chk(m_cnt == flen, {tag, " R9 done_cnt"}, m_cnt, flen);
        chk(m_runt == runt, {tag, " R10 runt flag"}, int'(m_runt), int'(runt));
        chk(m_crc == crcerr, {tag, " R11 crc flag"}, int'(m_crc), int'(crcerr));
        chk(m_rej == rej, {tag, " R8 reject flag"}, int'(m_rej), int'(rej));
        chk(chk_cnt == ((flen >= 8) ? 1 : 0), {tag, " R7 addr_chk count"}, chk_cnt, (flen >= 8) ? 1 : 0);
        if (flen >= 8) chk(chk_at == 7, {tag, " R7 addr_chk on byte 8"}, chk_at, 7);
    endtask

    task automatic check_silent(input string tag);
        chk(ncap == 0, {tag, " no bytes"}, ncap, 0);
        chk(done_seen == 0, {tag, " no done"}, done_seen, 0);
    endtask

    task automatic t_reset();
        chk(!out_valid && !out_last && !addr_chk && !done, "R1 reset outputs",
            int'({out_valid, out_last, addr_chk, done}), 0);
    endtask

    task automatic t_serial_std();
        clear_mon(); build_frame(60, 3, 0); send_serial(0);
        check_frame("R2 serial 64B", 0, 0, 0);
    endtask

    task automatic t_serial_early();
        clear_mon(); build_frame(20, 77, 0); send_serial(1);
        check_frame("R2 serial early pairs", 1, 0, 0);
    endtask

    task automatic t_serial_drop();
        clear_mon(); build_frame(60, 5, 0); send_serial(2);
        check_silent("R3 serial 00 drop");
    endtask

    task automatic t_mii_std();
        clear_mon(); build_frame(70, 11, 0); send_mii(15, 0, 0);
        check_frame("R4 mii 74B", 0, 0, 0);
    endtask

    task automatic t_mii_nopre_runt();
        clear_mon(); build_frame(59, 21, 0); send_mii(1, 0, 0);
        check_frame("R4 R10 mii 63B no preamble", 1, 0, 0);
    endtask

    task automatic t_mii_drop();
        clear_mon(); build_frame(60, 9, 0); send_mii(2, 1, 0);
        check_silent("R5 mii 00 drop");
    endtask

    task automatic t_crc_bad();
        clear_mon(); build_frame(62, 40, 1); send_mii(15, 0, 0);
        check_frame("R11 bad crc", 0, 1, 0);
    endtask

    task automatic t_rej_early();
        clear_mon(); build_frame(64, 50, 0); send_mii(15, 0, 1);
        check_frame("R8 reject before window", 0, 0, 0);
    endtask

    task automatic t_rej_late();
        clear_mon(); build_frame(64, 60, 0); send_mii(15, 0, 2);
        check_frame("R8 reject in window", 0, 0, 1);
    endtask

    task automatic t_short();
        clear_mon(); build_frame(2, 90, 0); send_mii(15, 0, 0);
        check_frame("R7 short frame", 1, 0, 0);
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_serial_std();
        t_serial_early();
        t_serial_drop();
        t_mii_std();
        t_mii_nopre_runt();
        t_mii_drop();
        t_crc_bad();
        t_rej_early();
        t_rej_late();
        t_short();
        t_serial_std();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule